// File: doc/BRIEF.md
# Data Access Address Translator and Fault Classifier

This block sits in the load/store path of a processor's memory management unit. For each access it takes a virtual address, the access size, the direction (load or store) and a few request qualifiers. It also takes the current and alternate privilege modes and the result of a translation-buffer lookup that a separate block performs. From these it decides, in a fixed priority order, whether the access faults. If it does not fault, the block forms the physical address and reports whether the access is uncacheable.

Every response carries a fault class and a six-bit memory-management status word. Bit 0 of the status word is write, bit 1 access violation, bit 2 fault-on-read, bit 3 fault-on-write, bit 4 translation miss and bit 5 bad virtual address. A request is accepted on any cycle that `req_valid` is high. The response appears on the `rsp_*` outputs exactly one clock later. The buffer storage and any event counting belong to other blocks.

Fault class encoding: 0 none, 1 misaligned, 2 page fault, 3 access violation, 4 page-table-entry miss, 5 normal miss, 6 machine check. Mode encoding: 0 kernel, 1 executive, 2 supervisor, 3 user. A mode selects bit `mode` of the per-entry enable vectors.

Top module: `dxl_xlate`

## Requirements
- R1: After reset all `rsp_*` outputs are zero. `rsp_valid` equals `req_valid` from the previous clock, and a response's fields describe the request accepted on that previous clock.
- R2: Misalignment has the highest priority. With `req_size` holding log2 of the byte count (0..3), the fault is class 1 if any of the low `req_size` address bits is set. The status word then carries only bit 0, which equals `req_write`. This holds whatever other fault would also apply.
- R3: The effective mode used for permission checks is `cur_mode` when `pc_lsb` is 0. When `pc_lsb` is 1, it is `alt_mode` if `req_alt` is 1 and kernel (0) otherwise.
- R4: Without `req_phys`, an address whose bits 63:43 are neither all zero nor all one gives class 2 with status bits 0 (= write), 1 and 5.
- R5: A valid address with bits 47:41 equal to 0x7e is a superpage access and ignores the lookup inputs. If `cur_mode` (not the effective mode) is not kernel, it gives class 3 with status bits 0 (= write) and 1. Otherwise the physical address is the low 40 bits, with bits 43:40 forced to one when bit 40 is set.
- R6: With `req_phys` set, an aligned access uses the virtual address as the physical address. The address validity check and the lookup inputs are then ignored.
- R7: A lookup miss gives class 4 when `req_pte` is set and class 5 otherwise. Its status word is bit 4 plus bit 0 (= write).
- R8: A store whose entry lacks `tlb_wr_en[mode]` gives class 2 with status bits 0 and 1, plus bit 3 if `tlb_fonw` is set. A permitted store with `tlb_fonw` set gives class 2 with status bits 0 and 3.
- R9: A load whose entry lacks `tlb_rd_en[mode]` gives class 3 with status bit 1, plus bit 2 if `tlb_fonr` is set. A permitted load with `tlb_fonr` set gives class 2 with status bit 2 only.
- R10: A permitted mapped access forms the physical address as `tlb_ppn` shifted left by 13, plus the low 13 virtual address bits.
- R11: A formed physical address with any bit at or above bit 44 gives class 6 with a zero status word.
- R12: A formed in-range physical address with bit 43 set is reported uncacheable, and its bits 42:35 are cleared in `rsp_pa`.
- R13: Any faulting response drives `rsp_pa` to zero and `rsp_uncached` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | log2 of the access size in bytes |
| req_write | input | 1 | 1 for a store, 0 for a load |
| pc_lsb | input | 1 | Bit 0 of the issuing program counter |
| req_phys | input | 1 | Address is already physical |
| req_alt | input | 1 | Use the alternate mode when the override applies |
| req_pte | input | 1 | Access fetches a page-table entry |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | Lookup found a matching entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Entry traps on read |
| tlb_fonw | input | 1 | Entry traps on write |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | Fault class |
| rsp_status | output | 6 | Memory-management status word |
| rsp_pa | output | 44 | Physical address, zero on a fault |
| rsp_uncached | output | 1 | Access is uncacheable |

## Verification
The bench sweeps every combination of program-counter bit, alternate flag, both mode registers, direction, enable patterns and trap bits. A design that indexed the enables by `cur_mode` instead of the effective mode, or swapped the read and write trap flags, would report the wrong class or status bits there. Misaligned requests are sent with otherwise-bad addresses, so a design that checked validity first would answer class 2 instead of 1. Superpage requests are sent with a user current mode but a kernel effective mode, so a design that used the effective mode would wrongly grant them. The physical-address edges are also exercised: bit 44 must raise a machine check, and bit 43 must strip bits 42:35. Both the superpage sign-extension path and the page path reach these edges.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

  // Address geometry
  parameter int VA_W       = 64;
  parameter int PA_W       = 44;
  parameter int PPN_W      = 32;
  parameter int PAGE_SHIFT = 13;
  parameter int VA_IMPL    = 43;   // bits at and above must be a sign copy
  parameter int SIZE_W     = 2;    // log2 of the byte count
  parameter int MODE_W     = 2;
  parameter int ST_W       = 6;

  // Superpage window and sign bit
  parameter int SP_HI   = 47;
  parameter int SP_LO   = 41;
  parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7e;
  parameter int SP_SIGN = 40;

  // Uncacheable stripping window
  parameter int UC_HI = 42;
  parameter int UC_LO = 35;

  localparam int NUM_MODES = 1 << MODE_W;
  localparam int LOW_W     = (1 << SIZE_W) - 1;   // address bits an access may span
  localparam int UC_BIT    = PA_W - 1;
  localparam int PAD_W     = VA_W - PPN_W - PAGE_SHIFT;
  localparam int HI_W      = VA_W - VA_IMPL;

  // Status word bit positions
  localparam int ST_WR   = 0;
  localparam int ST_ACV  = 1;
  localparam int ST_FONR = 2;
  localparam int ST_FONW = 3;
  localparam int ST_MISS = 4;
  localparam int ST_BAD  = 5;

  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_KERNEL = '0;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_PAGE  = 3'd2,
    FLT_ACV   = 3'd3,
    FLT_PMISS = 3'd4,
    FLT_NMISS = 3'd5,
    FLT_MCHK  = 3'd6
  } fault_e;

  function automatic logic addr_misaligned(input logic [VA_W-1:0] va,
                                           input logic [SIZE_W-1:0] sz);
    logic [LOW_W:0] span;
    span = ((LOW_W+1)'(1) << sz) - (LOW_W+1)'(1);
    return |(va[LOW_W-1:0] & span[LOW_W-1:0]);
  endfunction

  function automatic logic va_canonical(input logic [VA_W-1:0] va);
    logic [HI_W-1:0] hi;
    hi = va[VA_W-1:VA_IMPL];
    return (hi == '0) || (hi == '1);
  endfunction

  function automatic logic in_superpage(input logic [VA_W-1:0] va);
    return va[SP_HI:SP_LO] == SP_TAG;
  endfunction

  function automatic logic [VA_W-1:0] superpage_pa(input logic [VA_W-1:0] va);
    logic [VA_W-1:0] r;
    r = '0;
    r[SP_SIGN-1:0] = va[SP_SIGN-1:0];
    if (va[SP_SIGN]) r[PA_W-1:SP_SIGN] = '1;
    return r;
  endfunction

  function automatic logic [VA_W-1:0] page_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [VA_W-1:0] va);
    return {{PAD_W{1'b0}}, ppn, va[PAGE_SHIFT-1:0]};
  endfunction

  function automatic logic pa_in_range(input logic [VA_W-1:0] pa);
    return ~|pa[VA_W-1:PA_W];
  endfunction

  function automatic logic [PA_W-1:0] pa_strip(input logic [VA_W-1:0] pa);
    logic [PA_W-1:0] r;
    r = pa[PA_W-1:0];
    if (r[UC_BIT]) r[UC_HI:UC_LO] = '0;
    return r;
  endfunction

endpackage

// File: rtl/dxl_addr_screen.sv
module dxl_addr_screen
  import dxl_pkg::*;
(
  input  logic [VA_W-1:0]   va,
  input  logic [SIZE_W-1:0] size_log2,
  output logic              misaligned,
  output logic              bad_va,
  output logic              superpage
);
  always_comb begin
    misaligned = addr_misaligned(va, size_log2);
    bad_va     = !va_canonical(va);
    superpage  = in_superpage(va);
  end
endmodule

// File: rtl/dxl_mode_pick.sv
module dxl_mode_pick
  import dxl_pkg::*;
(
  input  logic  pc_lsb,
  input  logic  use_alt,
  input  mode_t cur_mode,
  input  mode_t alt_mode,
  output mode_t eff_mode
);
  always_comb begin
    if (!pc_lsb)      eff_mode = cur_mode;
    else if (use_alt) eff_mode = alt_mode;
    else              eff_mode = MODE_KERNEL;
  end
endmodule

// File: rtl/dxl_perm_judge.sv
module dxl_perm_judge
  import dxl_pkg::*;
(
  input  logic                 is_write,
  input  mode_t                mode,
  input  logic [NUM_MODES-1:0] rd_en,
  input  logic [NUM_MODES-1:0] wr_en,
  input  logic                 fonr,
  input  logic                 fonw,
  output fault_e               fault,
  output logic [ST_W-1:0]      status
);
  logic allowed;
  logic trap;

  always_comb begin
    allowed = is_write ? wr_en[mode] : rd_en[mode];
    trap    = is_write ? fonw : fonr;
    fault   = FLT_NONE;
    status  = '0;
    if (!allowed) begin
      // stores report a page fault class, loads an access violation
      fault           = is_write ? FLT_PAGE : FLT_ACV;
      status[ST_WR]   = is_write;
      status[ST_ACV]  = 1'b1;
      status[ST_FONR] = !is_write && fonr;
      status[ST_FONW] = is_write && fonw;
    end else if (trap) begin
      fault           = FLT_PAGE;
      status[ST_WR]   = is_write;
      status[ST_FONR] = !is_write;
      status[ST_FONW] = is_write;
    end
  end
endmodule

// File: rtl/dxl_pa_finish.sv
module dxl_pa_finish
  import dxl_pkg::*;
(
  input  logic [VA_W-1:0] pa_raw,
  output logic            in_range,
  output logic            uncached,
  output logic [PA_W-1:0] pa_out
);
  always_comb begin
    in_range = pa_in_range(pa_raw);
    uncached = pa_raw[UC_BIT];
    pa_out   = pa_strip(pa_raw);
  end
endmodule

// File: rtl/dxl_xlate.sv
module dxl_xlate
  import dxl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [63:0]      req_va,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic             pc_lsb,
  input  logic             req_phys,
  input  logic             req_alt,
  input  logic             req_pte,
  input  logic [1:0]       cur_mode,
  input  logic [1:0]       alt_mode,
  input  logic             tlb_hit,
  input  logic [31:0]      tlb_ppn,
  input  logic [3:0]       tlb_rd_en,
  input  logic [3:0]       tlb_wr_en,
  input  logic             tlb_fonr,
  input  logic             tlb_fonw,
  output logic             rsp_valid,
  output logic [2:0]       rsp_fault,
  output logic [5:0]       rsp_status,
  output logic [43:0]      rsp_pa,
  output logic             rsp_uncached
);

  // Named internal events
  logic            addr_misaligned_w;
  logic            addr_bad;
  logic            addr_super;
  mode_t           eff_mode;
  fault_e          perm_fault;
  logic [ST_W-1:0] perm_status;
  logic [VA_W-1:0] pa_raw;
  logic            pa_used;
  logic            pa_ok;
  logic            pa_uc;
  logic [PA_W-1:0] pa_final;
  fault_e          nxt_fault;
  logic [ST_W-1:0] nxt_status;
  logic [PA_W-1:0] nxt_pa;
  logic            nxt_uc;

  dxl_addr_screen u_screen (
    .va         (req_va),
    .size_log2  (req_size),
    .misaligned (addr_misaligned_w),
    .bad_va     (addr_bad),
    .superpage  (addr_super)
  );

  dxl_mode_pick u_mode (
    .pc_lsb   (pc_lsb),
    .use_alt  (req_alt),
    .cur_mode (cur_mode),
    .alt_mode (alt_mode),
    .eff_mode (eff_mode)
  );

  dxl_perm_judge u_perm (
    .is_write (req_write),
    .mode     (eff_mode),
    .rd_en    (tlb_rd_en),
    .wr_en    (tlb_wr_en),
    .fonr     (tlb_fonr),
    .fonw     (tlb_fonw),
    .fault    (perm_fault),
    .status   (perm_status)
  );

  dxl_pa_finish u_fin (
    .pa_raw   (pa_raw),
    .in_range (pa_ok),
    .uncached (pa_uc),
    .pa_out   (pa_final)
  );

  // Fault priority: alignment, physical bypass, VA validity,
  // superpage privilege, lookup miss, entry permission, PA range.
  always_comb begin
    nxt_fault  = FLT_NONE;
    nxt_status = '0;
    pa_raw     = '0;
    pa_used    = 1'b0;
    if (addr_misaligned_w) begin
      nxt_fault         = FLT_ALIGN;
      nxt_status[ST_WR] = req_write;
    end else if (req_phys) begin
      pa_raw  = req_va;
      pa_used = 1'b1;
    end else if (addr_bad) begin
      nxt_fault          = FLT_PAGE;
      nxt_status[ST_WR]  = req_write;
      nxt_status[ST_ACV] = 1'b1;
      nxt_status[ST_BAD] = 1'b1;
    end else if (addr_super) begin
      if (mode_t'(cur_mode) != MODE_KERNEL) begin
        nxt_fault          = FLT_ACV;
        nxt_status[ST_WR]  = req_write;
        nxt_status[ST_ACV] = 1'b1;
      end else begin
        pa_raw  = superpage_pa(req_va);
        pa_used = 1'b1;
      end
    end else if (!tlb_hit) begin
      nxt_fault           = req_pte ? FLT_PMISS : FLT_NMISS;
      nxt_status[ST_WR]   = req_write;
      nxt_status[ST_MISS] = 1'b1;
    end else if (perm_fault != FLT_NONE) begin
      nxt_fault  = perm_fault;
      nxt_status = perm_status;
    end else begin
      pa_raw  = page_pa(tlb_ppn, req_va);
      pa_used = 1'b1;
    end

    nxt_pa = '0;
    nxt_uc = 1'b0;
    if (pa_used) begin
      if (!pa_ok) begin
        nxt_fault  = FLT_MCHK;
        nxt_status = '0;
      end else begin
        nxt_pa = pa_final;
        nxt_uc = pa_uc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= '0;
      rsp_status   <= '0;
      rsp_pa       <= '0;
      rsp_uncached <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault    <= nxt_fault;
        rsp_status   <= nxt_status;
        rsp_pa       <= nxt_pa;
        rsp_uncached <= nxt_uc;
      end
    end
  end

endmodule

// File: rtl/dxl_xlate_chk.sv
module dxl_xlate_chk
  import dxl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_phys,
  input logic [1:0]      cur_mode,
  input logic            addr_misaligned_w,
  input logic            addr_bad,
  input logic            addr_super,
  input logic            rsp_valid,
  input logic [2:0]      rsp_fault,
  input logic [ST_W-1:0] rsp_status,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_uncached
);

  // R1
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && addr_misaligned_w) |=>
      (rsp_fault == FLT_ALIGN && rsp_status[ST_W-1:1] == '0));

  // R5
  super_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !addr_misaligned_w && !req_phys && !addr_bad && addr_super
      && cur_mode != MODE_KERNEL) |=> (rsp_fault == FLT_ACV));

  // R7
  miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault == FLT_PMISS || rsp_fault == FLT_NMISS)) |->
      (rsp_status[ST_MISS] && !rsp_status[ST_ACV] && !rsp_status[ST_BAD]));

  // R8 R9
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_status[ST_FONW:ST_FONR]) <= 1
                   && !(rsp_status[ST_FONR] && rsp_status[ST_WR])));

  // R12
  uncached_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_uncached) |->
      (rsp_pa[UC_BIT] && rsp_pa[UC_HI:UC_LO] == '0));

  // R13
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && !rsp_uncached));

endmodule

bind dxl_xlate dxl_xlate_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_valid         (req_valid),
  .req_phys          (req_phys),
  .cur_mode          (cur_mode),
  .addr_misaligned_w (addr_misaligned_w),
  .addr_bad          (addr_bad),
  .addr_super        (addr_super),
  .rsp_valid         (rsp_valid),
  .rsp_fault         (rsp_fault),
  .rsp_status        (rsp_status),
  .rsp_pa            (rsp_pa),
  .rsp_uncached      (rsp_uncached)
);

// File: tb/dxl_xlate_bench.sv
`timescale 1ns/1ps
module dxl_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        pc_lsb = 1'b0;
  logic        req_phys = 1'b0;
  logic        req_alt = 1'b0;
  logic        req_pte = 1'b0;
  logic [1:0]  cur_mode = '0;
  logic [1:0]  alt_mode = '0;
  logic        tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0;
  logic [3:0]  tlb_wr_en = '0;
  logic        tlb_fonr = 1'b0;
  logic        tlb_fonw = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [5:0]  rsp_status;
  logic [43:0] rsp_pa;
  logic        rsp_uncached;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  dxl_xlate u_dxl_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_size(req_size), .req_write(req_write), .pc_lsb(pc_lsb),
    .req_phys(req_phys), .req_alt(req_alt), .req_pte(req_pte),
    .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
    .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_status(rsp_status), .rsp_pa(rsp_pa),
    .rsp_uncached(rsp_uncached)
  );

  // Drive one request at a negedge, predict, check at the next negedge.
  task automatic apply(input logic [63:0] va, input logic [1:0] sz,
                       input logic wr, input logic pc0, input logic phys,
                       input logic alt, input logic pte,
                       input logic [1:0] cm, input logic [1:0] am,
                       input logic hit, input logic [31:0] ppn,
                       input logic [3:0] rde, input logic [3:0] wre,
                       input logic fr, input logic fw);
    logic [63:0] p;
    logic        usep;
    logic [2:0]  ef;
    logic [5:0]  es;
    logic [43:0] epa;
    logic        euc;
    logic [20:0] up;
    logic        allowed;
    logic        fon;
    int          em;
    string       tag;
    req_va = va; req_size = sz; req_write = wr; pc_lsb = pc0; req_phys = phys;
    req_alt = alt; req_pte = pte; cur_mode = cm; alt_mode = am; tlb_hit = hit;
    tlb_ppn = ppn; tlb_rd_en = rde; tlb_wr_en = wre; tlb_fonr = fr; tlb_fonw = fw;
    req_valid = 1'b1;

    p = '0; usep = 1'b0; ef = 3'd0; es = 6'd0; epa = '0; euc = 1'b0; tag = "";
    em = pc0 ? (alt ? int'(am) : 0) : int'(cm);
    up = va[63:43];
    if ((va % (64'd1 << sz)) != 64'd0) begin
      ef = 3'd1; es = {5'd0, wr}; tag = "R2";
    end else if (phys) begin
      p = va; usep = 1'b1; tag = "R6";
    end else if (up != 21'd0 && up != 21'h1FFFFF) begin
      ef = 3'd2; es = 6'd34 + {5'd0, wr}; tag = "R4";
    end else if (va[47:41] == 7'h7e) begin
      tag = "R5";
      if (cm != 2'd0) begin
        ef = 3'd3; es = 6'd2 + {5'd0, wr};
      end else begin
        p = va % (64'd1 << 40);
        if (va[40]) p = p + 64'h0000_0F00_0000_0000;
        usep = 1'b1;
      end
    end else if (!hit) begin
      ef = pte ? 3'd4 : 3'd5; es = 6'd16 + {5'd0, wr}; tag = "R7";
    end else begin
      allowed = wr ? wre[em] : rde[em];
      fon = wr ? fw : fr;
      tag = wr ? "R8" : "R9";
      if (pc0) tag = {"R3 ", tag};
      if (!allowed) begin
        ef = wr ? 3'd2 : 3'd3;
        es = 6'd2 + {5'd0, wr} + ((wr && fw) ? 6'd8 : 6'd0) + ((!wr && fr) ? 6'd4 : 6'd0);
      end else if (fon) begin
        ef = 3'd2;
        es = wr ? 6'd9 : 6'd4;
      end else begin
        p = {32'd0, ppn} * 64'd8192 + (va % 64'd8192);
        usep = 1'b1;
        tag = {tag, " R10"};
      end
    end
    if (usep) begin
      if (p >= (64'd1 << 44)) begin
        ef = 3'd6; es = 6'd0; tag = {tag, " R11"};
      end else if (p[43]) begin
        euc = 1'b1;
        epa = 44'(p) & ~(44'hFF << 35);
        tag = {tag, " R12"};
      end else begin
        epa = 44'(p);
      end
    end
    if (ef != 3'd0) tag = {tag, " R13"};

    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_status !== es ||
        rsp_pa !== epa || rsp_uncached !== euc) begin
      bad++;
      $display("FAIL %s R1 va=%h: got v=%b f=%0d st=%b pa=%h uc=%b exp v=1 f=%0d st=%b pa=%h uc=%b",
               tag, va, rsp_valid, rsp_fault, rsp_status, rsp_pa, rsp_uncached,
               ef, es, epa, euc);
    end
  endtask

  task automatic check_idle(input string tag);
    total++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 3'd0 || rsp_status !== 6'd0 ||
        rsp_pa !== 44'd0 || rsp_uncached !== 1'b0) begin
      bad++;
      $display("FAIL %s: got v=%b f=%0d st=%b pa=%h uc=%b exp all zero",
               tag, rsp_valid, rsp_fault, rsp_status, rsp_pa, rsp_uncached);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");

    // R2: alignment before a bad address, all sizes and offsets
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        for (int w = 0; w < 2; w++)
          apply(64'h8000_0000_0000_1000 | 64'(o), 2'(s), 1'(w), 1'b0, 1'b0,
                1'b0, 1'b0, 2'd3, 2'd0, 1'b1, 32'h10, 4'hF, 4'hF, 1'b0, 1'b0);

    // R3 R8 R9 R10: mode override against every enable pattern
    for (int pc = 0; pc < 2; pc++)
      for (int al = 0; al < 2; al++)
        for (int cm = 0; cm < 4; cm++)
          for (int am = 0; am < 4; am++)
            for (int w = 0; w < 2; w++)
              for (int e = 0; e < 16; e++)
                for (int t = 0; t < 4; t++)
                  apply(64'h0000_0012_3456_7888, 2'd3, 1'(w), 1'(pc), 1'b0,
                        1'(al), 1'b0, 2'(cm), 2'(am), 1'b1, 32'h0001_2345,
                        4'(e), 4'(e) ^ 4'b1010, t[0], t[1]);

    // R4: single stray bits above the implemented range
    for (int b = 43; b < 63; b++)
      for (int w = 0; w < 2; w++)
        apply(64'd1 << b, 2'd0, 1'(w), 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0,
              1'b1, 32'h5, 4'hF, 4'hF, 1'b0, 1'b0);
    apply(64'h7FFF_F800_0000_0040, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0,
          2'd0, 1'b1, 32'h5, 4'hF, 4'hF, 1'b0, 1'b0);
    // canonical negative address reaches the lookup (R10)
    apply(64'hFFFF_F800_0000_1230, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b1, 32'h0000_0ABC, 4'hF, 4'h0, 1'b0, 1'b0);

    // R5 R12: superpage, current mode vs effective mode, lookup ignored
    for (int cm = 0; cm < 4; cm++)
      for (int b40 = 0; b40 < 2; b40++)
        for (int w = 0; w < 2; w++)
          apply(64'hFFFF_FC00_0000_0000 | (64'(b40) << 40) | 64'h98_7654_3320,
                2'd2, 1'(w), 1'b1, 1'b0, 1'b0, 1'b0, 2'(cm), 2'd3,
                1'b0, 32'hFFFF_FFFF, 4'h0, 4'h0, 1'b1, 1'b1);

    // R6 R11 R12: physical bypass
    apply(64'h0000_0123_4567_89A8, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0);
    apply(64'h0000_0800_0000_0040, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0);
    apply(64'h0000_0FF8_0000_0010, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0);
    apply(64'h0000_1000_0000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b0, 32'h0, 4'h0, 4'h0, 1'b0, 1'b0);
    apply(64'h8000_0000_0000_0000, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b1, 32'h1, 4'hF, 4'hF, 1'b0, 1'b0);

    // R7: both miss classes, both directions
    for (int pt = 0; pt < 2; pt++)
      for (int w = 0; w < 2; w++)
        apply(64'h0000_0000_0040_2000, 2'd1, 1'(w), 1'b0, 1'b0, 1'b0, 1'(pt),
              2'd1, 2'd0, 1'b0, 32'h77, 4'hF, 4'hF, 1'b1, 1'b1);

    // R11 R12: page path reaching the physical edges
    apply(64'h0000_0000_0000_0abc, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b1, 32'h8000_0000, 4'hF, 4'hF, 1'b0, 1'b0);
    apply(64'h0000_0000_0000_1abc, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b1, 32'h4000_0000, 4'hF, 4'hF, 1'b0, 1'b0);
    apply(64'h0000_0000_0000_0ff0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3,
          2'd0, 1'b1, 32'h47F8_0001, 4'hF, 4'hF, 1'b0, 1'b0);

    // R1: idle cycle drops the response valid
    req_valid = 1'b0;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle: got v=%b exp v=0", rsp_valid);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule